// File: doc/BRIEF.md
# Per-VC Cut-Through Cell Classifier

This block sits on a network interface chip that is one link in a chain of such chips. It sees the header of every cell that passes through. For each cell it produces one of three decisions. The cell may go on to the next chip in the chain. It may be handed to the local processor. Or it may go straight to the switch on the fast path. The decision is based on the cell's virtual channel identifier (VCI) and on a small per-channel state machine held in a direct-mapped table.

Software claims the channels its processor owns. At first a claimed channel is idle. The first cell that uses it makes it active, and that cell goes to the processor. Once the processor has drained whatever it buffered for the flow, it grants the channel. From then on the channel's cells bypass the processor. Software can later withdraw the grant, or an output overload can withdraw it. In both cases the change is held back until a packet ends, so that no packet is split between the two paths. A reset control cell sent down the channel returns it to idle, and software can also return it to idle directly.

Per-channel states: IDLE (inactive), DIVERT (active, cells to the processor), CUT (active, cells to the switch) and DRAIN (active, cells still to the switch, diversion pending). Transitions:
- IDLE→DIVERT on an ordinary cell.
- DIVERT→CUT on a grant.
- DRAIN→CUT on a grant.
- CUT→DRAIN on a release, or on a non-final cell during overload.
- CUT→DIVERT on a final cell during overload.
- DRAIN→DIVERT on a final cell.
- any state→IDLE on a reset cell or on a deactivate.
- claim→IDLE.

Top module: `vc_cut_classifier`

## Requirements
- R1: A cell whose full 16-bit VCI does not equal the VCI of a claimed table entry is given code 2'b00 (chain). This includes a VCI that shares the low 8 index bits with a claimed entry but differs in the upper bits.
- R2: For each cycle with `cell_vld` high, `dec_vld` is high in the following cycle, `dec_vci` echoes the VCI, and `dec_code` carries the decision. With no cell, `dec_vld` is low.
- R3: After reset no channel is owned, and the outputs are `dec_vld`=0 and `dec_code`=2'b00. Configuration op 2'b00 (claim) on `cfg_vci` makes that channel owned and IDLE.
- R4: An ordinary cell on an owned IDLE channel gets code 2'b01 (processor) and moves the channel to DIVERT. Later cells keep getting 2'b01 until a grant.
- R5: Op 2'b01 (grant) on an owned DIVERT or DRAIN channel moves it to CUT, and its cells then get code 2'b10 (switch). A grant on an IDLE channel is ignored.
- R6: Op 2'b10 (release) on a CUT channel defers the change. Cells keep getting 2'b10 up to and including the next end-of-packet cell (PTI bit 2 = 0 and PTI bit 0 = 1). Cells after that get 2'b01.
- R7: While `link_ovld` is high, a cell on a CUT channel still gets 2'b10. The channel diverts to 2'b01 starting with the first cell after an end-of-packet cell.
- R8: A reset control cell (PTI = 3'b110) on an owned channel gets code 2'b01 and leaves the channel IDLE, from any state. On an unowned VCI it gets 2'b00.
- R9: Op 2'b11 (deactivate) returns an owned channel to IDLE and clears its grant. The next cell gets 2'b01 and activates the channel.
- R10: A claim on a table index held by a different VCI replaces the old owner. The old VCI then chains (2'b00) and the new one follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | A cell header is present this cycle |
| cell_vci | input | 16 | VCI of the cell |
| cell_pti | input | 3 | Payload type field of the cell |
| link_ovld | input | 1 | Output buffer overload indication |
| cfg_we | input | 1 | Configuration operation strobe |
| cfg_op | input | 2 | 00 claim, 01 grant, 10 release, 11 deactivate |
| cfg_vci | input | 16 | Channel addressed by the operation |
| dec_vld | output | 1 | Decision valid, one cycle after the header |
| dec_code | output | 2 | 00 chain, 01 processor, 10 switch |
| dec_vci | output | 16 | VCI the decision belongs to |

## Verification
A channel stuck in a wrong state shows at the ports on the very next cell of that channel. The code is one cycle after the header and is 01 where 10 is expected, or the reverse. Some states give the same code as each other: IDLE and DIVERT both give 01, and CUT and DRAIN both give 10. These are told apart by a follow-up. A grant is ignored only when the channel is IDLE. An end-of-packet cell flips only a DRAIN channel. A deferred diversion that fires too early or too late shows as a wrong code on the cell just before or just after the packet boundary.

// File: rtl/vcc_pkg.sv
`timescale 1ns/1ps
package vcc_pkg;
    typedef enum logic [1:0] {
        VC_IDLE   = 2'b00,
        VC_DIVERT = 2'b01,
        VC_CUT    = 2'b10,
        VC_DRAIN  = 2'b11
    } vc_state_t;

    typedef enum logic [1:0] {
        DEC_CHAIN  = 2'b00,
        DEC_PROC   = 2'b01,
        DEC_SWITCH = 2'b10
    } dec_t;

    typedef enum logic [1:0] {
        OP_CLAIM   = 2'b00,
        OP_GRANT   = 2'b01,
        OP_RELEASE = 2'b10,
        OP_DEACT   = 2'b11
    } cfg_op_t;

    localparam logic [2:0] PTI_RESET_CELL = 3'b110;
endpackage

// File: rtl/vcc_hdr_dec.sv
`timescale 1ns/1ps
module vcc_hdr_dec
    import vcc_pkg::*;
(
    input  logic [2:0] pti,
    output logic       is_eop,
    output logic       is_rst
);
    // user cell with the end-of-packet indication set
    assign is_eop = !pti[2] && pti[0];
    assign is_rst = (pti == PTI_RESET_CELL);
endmodule

// File: rtl/vcc_vc_fsm.sv
`timescale 1ns/1ps
module vcc_vc_fsm
    import vcc_pkg::*;
(
    input  vc_state_t cur,
    input  logic      is_rst,
    input  logic      is_eop,
    input  logic      ovld,
    output vc_state_t nxt,
    output dec_t      code
);
    always_comb begin
        nxt  = cur;
        code = DEC_PROC;
        unique case (cur)
            VC_IDLE: begin
                code = DEC_PROC;
                nxt  = is_rst ? VC_IDLE : VC_DIVERT;
            end
            VC_DIVERT: begin
                code = DEC_PROC;
                nxt  = is_rst ? VC_IDLE : VC_DIVERT;
            end
            VC_CUT: begin
                if (is_rst) begin
                    code = DEC_PROC;
                    nxt  = VC_IDLE;
                end else begin
                    code = DEC_SWITCH;
                    if (ovld) nxt = is_eop ? VC_DIVERT : VC_DRAIN;
                    else      nxt = VC_CUT;
                end
            end
            VC_DRAIN: begin
                if (is_rst) begin
                    code = DEC_PROC;
                    nxt  = VC_IDLE;
                end else begin
                    code = DEC_SWITCH;
                    nxt  = is_eop ? VC_DIVERT : VC_DRAIN;
                end
            end
        endcase
    end
endmodule

// File: rtl/vcc_vc_table.sv
`timescale 1ns/1ps
module vcc_vc_table
    import vcc_pkg::*;
#(
    parameter int VCI_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_vld,
    input  logic [VCI_W-1:0] cell_vci,
    input  logic             is_rst,
    input  logic             is_eop,
    input  logic             ovld,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_op_i,
    input  logic [VCI_W-1:0] cfg_vci,
    output logic             hit,
    output dec_t             code
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = VCI_W - IDX_W;

    logic [DEPTH-1:0] own_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    vc_state_t        st_q  [DEPTH];

    logic [IDX_W-1:0] idx, cidx;
    logic [TAG_W-1:0] ctag, cfg_tag;
    vc_state_t        cur, cfg_cur, nxt;
    dec_t             fsm_code;
    logic             cfg_hit;
    cfg_op_t          op;

    assign idx     = cell_vci[IDX_W-1:0];
    assign ctag    = cell_vci[VCI_W-1:IDX_W];
    assign cidx    = cfg_vci[IDX_W-1:0];
    assign cfg_tag = cfg_vci[VCI_W-1:IDX_W];
    assign op      = cfg_op_t'(cfg_op_i);
    assign hit     = own_q[idx] && (tag_q[idx] == ctag);
    assign cur     = st_q[idx];
    assign cfg_hit = own_q[cidx] && (tag_q[cidx] == cfg_tag);
    assign cfg_cur = st_q[cidx];

    vcc_vc_fsm u_fsm (
        .cur    (cur),
        .is_rst (is_rst),
        .is_eop (is_eop),
        .ovld   (ovld),
        .nxt    (nxt),
        .code   (fsm_code)
    );

    assign code = hit ? fsm_code : DEC_CHAIN;

    // ownership bits: the only reset state of the table
    always_ff @(posedge clk) begin
        if (!rst_n)                         own_q       <= '0;
        else if (cfg_we && op == OP_CLAIM)  own_q[cidx] <= 1'b1;
    end

    // per-channel state register; configuration wins a same-index collision
    always_ff @(posedge clk) begin
        if (cell_vld && hit) st_q[idx] <= nxt;
        if (cfg_we) begin
            unique case (op)
                OP_CLAIM: begin
                    tag_q[cidx] <= cfg_tag;
                    st_q[cidx]  <= VC_IDLE;
                end
                OP_GRANT:
                    if (cfg_hit && (cfg_cur == VC_DIVERT || cfg_cur == VC_DRAIN))
                        st_q[cidx] <= VC_CUT;
                OP_RELEASE:
                    if (cfg_hit && cfg_cur == VC_CUT) st_q[cidx] <= VC_DRAIN;
                OP_DEACT:
                    if (cfg_hit) st_q[cidx] <= VC_IDLE;
            endcase
        end
    end

    // checker state
    logic [IDX_W-1:0] cell_idx_q, cfg_idx_q;
    logic             col;
    assign col = cfg_we && (cidx == idx);
    always_ff @(posedge clk) begin
        cell_idx_q <= idx;
        cfg_idx_q  <= cidx;
    end

    assert_activate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld && hit && cur == VC_IDLE && !is_rst && !col
        |=> st_q[cell_idx_q] == VC_DIVERT);

    assert_rstcell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld && hit && is_rst && !col |=> st_q[cell_idx_q] == VC_IDLE);

    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld && hit && cur == VC_DRAIN && !is_eop && !is_rst && !col
        |=> st_q[cell_idx_q] == VC_DRAIN);

    assert_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && op == OP_GRANT && cfg_hit && cfg_cur == VC_DIVERT
        |=> st_q[cfg_idx_q] == VC_CUT);

    assert_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && op == OP_CLAIM
        |=> own_q[cfg_idx_q] && st_q[cfg_idx_q] == VC_IDLE);
endmodule

// File: rtl/vc_cut_classifier.sv
`timescale 1ns/1ps
module vc_cut_classifier
    import vcc_pkg::*;
#(
    parameter int VCI_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_vld,
    input  logic [VCI_W-1:0] cell_vci,
    input  logic [2:0]       cell_pti,
    input  logic             link_ovld,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_op,
    input  logic [VCI_W-1:0] cfg_vci,
    output logic             dec_vld,
    output logic [1:0]       dec_code,
    output logic [VCI_W-1:0] dec_vci
);
    logic is_eop, is_rst, hit;
    dec_t code;

    vcc_hdr_dec u_dec (
        .pti    (cell_pti),
        .is_eop (is_eop),
        .is_rst (is_rst)
    );

    vcc_vc_table #(.VCI_W(VCI_W), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_vld (cell_vld),
        .cell_vci (cell_vci),
        .is_rst   (is_rst),
        .is_eop   (is_eop),
        .ovld     (link_ovld),
        .cfg_we   (cfg_we),
        .cfg_op_i (cfg_op),
        .cfg_vci  (cfg_vci),
        .hit      (hit),
        .code     (code)
    );

    // output register: decision one cycle after the header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= 1'b0;
            dec_code <= DEC_CHAIN;
            dec_vci  <= '0;
        end else begin
            dec_vld  <= cell_vld;
            dec_code <= cell_vld ? code : DEC_CHAIN;
            dec_vci  <= cell_vci;
        end
    end

    assert_dec_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld |=> dec_vld);

    assert_miss_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld && !hit |=> dec_code == DEC_CHAIN);
endmodule

// File: tb/sim_vc_cut_classifier.sv
`timescale 1ns/1ps
module sim_vc_cut_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_vld = 1'b0;
    logic [15:0] cell_vci = '0;
    logic [2:0]  cell_pti = '0;
    logic        link_ovld = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = '0;
    logic [15:0] cfg_vci = '0;
    logic        dec_vld;
    logic [1:0]  dec_code;
    logic [15:0] dec_vci;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vc_cut_classifier u0 (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_vci(cell_vci),
        .cell_pti(cell_pti), .link_ovld(link_ovld), .cfg_we(cfg_we),
        .cfg_op(cfg_op), .cfg_vci(cfg_vci), .dec_vld(dec_vld),
        .dec_code(dec_code), .dec_vci(dec_vci)
    );

    typedef struct packed {
        logic        cfg_en;
        logic [1:0]  op;
        logic [15:0] cvci;
        logic [15:0] vci;
        logic [2:0]  pti;
        logic        ovld;
        logic [1:0]  exp;
        logic [3:0]  req;
    } vec_t;

    // A=0123, B=0245, C=0523 (same index as A), op 0 claim 1 grant 2 release 3 deact
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b000, 1'b0, 2'b00, 4'd1},  // R1 unowned after reset
        '{1'b1, 2'd0, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b01, 4'd4},  // R4 claim, first cell
        '{1'b0, 2'd0, 16'h0000, 16'h0523, 3'b000, 1'b0, 2'b00, 4'd1},  // R1 alias index
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b001, 1'b0, 2'b01, 4'd4},  // R4 still diverted
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b10, 4'd5},  // R5 grant
        '{1'b1, 2'd2, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b10, 4'd6},  // R6 release deferred
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b001, 1'b0, 2'b10, 4'd6},  // R6 eop still switch
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b000, 1'b0, 2'b01, 4'd6},  // R6 diverted
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b10, 4'd5},  // R5 regrant
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b000, 1'b1, 2'b10, 4'd7},  // R7 overload mid packet
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b001, 1'b1, 2'b10, 4'd7},  // R7 overload eop
        '{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b000, 1'b0, 2'b01, 4'd7},  // R7 diverted
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b110, 1'b0, 2'b01, 4'd8},  // R8 reset cell on CUT
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b01, 4'd8},  // R8 idle: grant ignored
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b10, 4'd5},  // R5 grant after activation
        '{1'b1, 2'd3, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b01, 4'd9},  // R9 deactivate
        '{1'b1, 2'd1, 16'h0123, 16'h0123, 3'b000, 1'b0, 2'b10, 4'd9},  // R9 reactivated path
        '{1'b1, 2'd0, 16'h0245, 16'h0245, 3'b110, 1'b0, 2'b01, 4'd8},  // R8 reset cell on idle
        '{1'b1, 2'd1, 16'h0245, 16'h0245, 3'b000, 1'b0, 2'b01, 4'd8},  // R8 stayed idle
        '{1'b0, 2'd0, 16'h0000, 16'h0777, 3'b110, 1'b0, 2'b00, 4'd8},  // R8 unowned reset cell
        '{1'b1, 2'd0, 16'h0523, 16'h0123, 3'b000, 1'b0, 2'b00, 4'd10}, // R10 old owner chains
        '{1'b0, 2'd0, 16'h0000, 16'h0523, 3'b000, 1'b0, 2'b01, 4'd10}  // R10 new owner
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.req);
        @(negedge clk);
        cfg_we = v.cfg_en; cfg_op = v.op; cfg_vci = v.cvci;
        @(negedge clk);
        cfg_we = 1'b0;
        cell_vld = 1'b1; cell_vci = v.vci; cell_pti = v.pti; link_ovld = v.ovld;
        @(negedge clk);
        cell_vld = 1'b0; link_ovld = 1'b0;
        check(rq, "dec_code", {14'd0, dec_code}, {14'd0, v.exp});
        check("R2", "dec_vld", {15'd0, dec_vld}, 16'd1);
        check("R2", "dec_vci", dec_vci, v.vci);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R3", "reset dec_vld", {15'd0, dec_vld}, 16'd0);
        check("R3", "reset dec_code", {14'd0, dec_code}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2", "idle dec_vld", {15'd0, dec_vld}, 16'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3: a mid-run reset clears ownership of A
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        run_vec('{1'b0, 2'd0, 16'h0000, 16'h0123, 3'b000, 1'b0, 2'b00, 4'd3});

        // R2: back-to-back cells, one decision per cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = 2'd0; cfg_vci = 16'h0123;
        @(negedge clk);
        cfg_we = 1'b0;
        cell_vld = 1'b1; cell_vci = 16'h0123; cell_pti = 3'b000;
        @(negedge clk);
        cell_vci = 16'h0999;
        check("R2", "b2b first code", {14'd0, dec_code}, 16'h0001);
        check("R2", "b2b first vci", dec_vci, 16'h0123);
        @(negedge clk);
        cell_vld = 1'b0;
        check("R2", "b2b second code", {14'd0, dec_code}, 16'h0000);
        check("R2", "b2b second vci", dec_vci, 16'h0999);
        @(negedge clk);
        check("R2", "b2b drop vld", {15'd0, dec_vld}, 16'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule